// File: doc/BRIEF.md
# Byte-Serial CRC-16 Generator

This block folds a stream of bytes into a 16-bit cyclic redundancy check for frame integrity protection. Bytes arrive through a valid/ready handshake. A start-of-frame strobe, given with the first byte, reloads the register with all ones in the same cycle that the byte is absorbed. A last-byte flag marks the end of the frame. The running remainder is visible on `crc_o` at all times. `done_o` pulses once the final byte has been fully processed.

The generator polynomial is x^16 + x^12 + x^5 + 1 (0x1021 with the top term implicit). Bits are taken most significant first, and each byte is XORed into the upper half of the register before its shift steps. The result is not reflected and has no final XOR.

The parameter `STEPS_PER_CYCLE` selects the datapath:
- **Stepped (1, 2 or 4).** One absorb cycle is followed by 8/`STEPS_PER_CYCLE` step cycles. `in_ready_o` is low during the step cycles.
- **Fused (8).** The absorb and all eight steps are unrolled into one combinational path, and the block takes one byte per clock.

Top module: `crc16_byte_engine`

## Requirements
- R1: Each shift step moves the register left by one bit and XORs in 0x1021 exactly when bit 15 was 1 before the shift. With `STEPS_PER_CYCLE`=1, one such step is visible on `crc_o` per clock. After 0x48 is absorbed into the preset, the first step gives 0x7FDF.
- R2: A byte accepted with `sof_i` high starts from 0xFFFF, whatever the register held before.
- R3: An accepted byte is XORed into bits 15..8 of the register before its steps. In the stepped form, `crc_o` shows this value in the cycle after acceptance (0xB7FF for first byte 0x48). A byte accepted without `sof_i` continues from the value currently held.
- R4: The final value has no reflection and no final XOR. Bytes 0x48 then 0x69 give 0x64E5, and longer frames match a bitwise MSB-first model.
- R5: A byte is taken only when `in_valid_i` and `in_ready_o` are both high. In the stepped form, `in_ready_o` is low for the 8/`STEPS_PER_CYCLE` cycles after each acceptance and high again afterwards. `in_valid_i`, `in_data_i` and `sof_i` presented while it is low have no effect.
- R6: In the fused form, `in_ready_o` stays high and back-to-back bytes are taken one per clock.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last step of a byte accepted with `last_i` high. In the fused form this is the cycle after that byte's acceptance. It stays low for bytes without `last_i`.
- R8: `crc_o` does not change in any cycle in which no byte is accepted and no step is pending.
- R9: Reset (`rst_ni` low, asynchronous) sets `crc_o` to 0xFFFF, `in_ready_o` high and `done_o` low, and abandons any byte in progress.
- R10: `sof_i` given in the middle of a frame discards the partial remainder and restarts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of frame, qualified by acceptance |
| in_valid_i | input | 1 | Byte on `in_data_i` is valid |
| in_data_i | input | 8 | Input byte |
| last_i | input | 1 | Byte is the last of the frame, qualified by acceptance |
| in_ready_o | output | 1 | Block can accept a byte this cycle |
| crc_o | output | 16 | Running CRC remainder |
| done_o | output | 1 | One-cycle pulse: final byte fully processed |

## Verification
The hardest case to reach from the ports is a byte or a start strobe offered while the stepped datapath is still busy. Such stimulus must leave both the remainder in progress and the next acceptance untouched. The bench reaches this case by holding `in_valid_i` and `sof_i` high with a foreign byte right after 0x48 is accepted. It checks that `crc_o` still steps to 0x7FDF and that the frame still closes at 0x64E5. Intermediate register values are observable in the one-bit stepped form. A second instance in the fused form covers back-to-back acceptance with a known answer and a reload on the next frame.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc16_step.sv
// N chained MSB-first shift/conditional-XOR steps, purely combinational.
module crc16_step #(
  parameter int unsigned          W    = 16,
  parameter int unsigned          N    = 1,
  parameter logic [W-1:0]         POLY = 16'h1021
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] chain [N+1];

  assign chain[0] = state_i;

  for (genvar k = 0; k < N; k++) begin : g_step
    logic [W-1:0] shifted;
    assign shifted    = {chain[k][W-2:0], 1'b0};
    assign chain[k+1] = chain[k][W-1] ? (shifted ^ POLY) : shifted;
  end

  assign state_o = chain[N];
endmodule

// File: rtl/crc16_ctrl.sv
// Handshake, step sequencing and done generation.
module crc16_ctrl #(
  parameter int unsigned STEPS_PER_CYCLE = 1,
  parameter int unsigned BYTE_W          = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic last_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic step_en_o,
  output logic done_o
);
  localparam bit          FUSED  = (STEPS_PER_CYCLE >= BYTE_W);
  localparam int unsigned PASSES = FUSED ? 1 : BYTE_W / STEPS_PER_CYCLE;
  localparam int unsigned CNT_W  = $clog2(PASSES + 1);

  logic done_q;
  assign done_o = done_q;

  if (FUSED) begin : g_fused
    assign in_ready_o = 1'b1;
    assign accept_o   = in_valid_i;
    assign step_en_o  = 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) done_q <= 1'b0;
      else         done_q <= accept_o & last_i;
    end

    // R7
    done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && last_i) |=> done_o);
  end else begin : g_stepped
    logic [CNT_W-1:0] cnt_q;
    logic             last_q;
    logic             busy;

    assign busy       = (cnt_q != '0);
    assign in_ready_o = ~busy;
    assign accept_o   = in_valid_i & ~busy;
    assign step_en_o  = busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        last_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        done_q <= busy && (cnt_q == CNT_W'(1)) && last_q;
        if (accept_o) begin
          cnt_q  <= CNT_W'(PASSES);
          last_q <= last_i;
        end else if (busy) begin
          cnt_q  <= cnt_q - CNT_W'(1);
        end
      end
    end

    // R5
    ready_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |=> !in_ready_o);
    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
    // R7
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> in_ready_o);
  end
endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
  import crc16_pkg::*;
#(
  parameter int unsigned     STEPS_PER_CYCLE = 1,   // 1, 2, 4 or 8 (8 = fused)
  parameter logic [CRC_W-1:0] POLY           = CRC_POLY,
  parameter logic [CRC_W-1:0] PRESET         = CRC_PRESET
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              last_i,
  output logic              in_ready_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  localparam bit          FUSED = (STEPS_PER_CYCLE >= BYTE_W);
  localparam int unsigned NSTEP = FUSED ? BYTE_W : STEPS_PER_CYCLE;
  localparam int unsigned PAD_W = CRC_W - BYTE_W;

  logic accept, step_en;
  crc_t crc_q, base, absorbed, step_in, step_out;

  crc16_ctrl #(
    .STEPS_PER_CYCLE(STEPS_PER_CYCLE),
    .BYTE_W         (BYTE_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .last_i     (last_i),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .step_en_o  (step_en),
    .done_o     (done_o)
  );

  assign base     = sof_i ? PRESET : crc_q;
  assign absorbed = base ^ {in_data_i, {PAD_W{1'b0}}};
  assign step_in  = FUSED ? absorbed : crc_q;

  crc16_step #(
    .W    (CRC_W),
    .N    (NSTEP),
    .POLY (POLY)
  ) u_step (
    .state_i (step_in),
    .state_o (step_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= PRESET;
    else if (accept)   crc_q <= FUSED ? step_out : absorbed;
    else if (step_en)  crc_q <= step_out;
  end

  assign crc_o = crc_q;

  // R8
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !step_en) |=> $stable(crc_o));

  if (!FUSED) begin : g_stepped_chk
    // R2
    sof_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && sof_i) |=> crc_o == (PRESET ^ {$past(in_data_i), {PAD_W{1'b0}}}));
    // R3
    absorb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !sof_i) |=> crc_o == ($past(crc_o) ^ {$past(in_data_i), {PAD_W{1'b0}}}));
  end

  if (STEPS_PER_CYCLE == 1) begin : g_bit_chk
    // R1
    bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_en |=> crc_o == ({$past(crc_o[CRC_W-2:0]), 1'b0} ^
                            ($past(crc_o[CRC_W-1]) ? POLY : '0)));
  end
endmodule

// File: tb/crc16_byte_engine_tb.sv
module crc16_byte_engine_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n;
  logic s_sof, s_valid, s_last; logic [7:0] s_data;
  logic s_ready, s_done; logic [15:0] s_crc;
  logic f_sof, f_valid, f_last; logic [7:0] f_data;
  logic f_ready, f_done; logic [15:0] f_crc;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] frame [16];

  crc16_byte_engine #(.STEPS_PER_CYCLE(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(s_sof), .in_valid_i(s_valid),
    .in_data_i(s_data), .last_i(s_last), .in_ready_o(s_ready),
    .crc_o(s_crc), .done_o(s_done));

  crc16_byte_engine #(.STEPS_PER_CYCLE(8)) u_fast (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(f_sof), .in_valid_i(f_valid),
    .in_data_i(f_data), .last_i(f_last), .in_ready_o(f_ready),
    .crc_o(f_crc), .done_o(f_done));

  function automatic logic [15:0] ref_byte(input logic [15:0] seed, input logic [7:0] b);
    logic [15:0] r;
    r = seed ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Ends at the negedge right after the accepting edge.
  task automatic s_send(input logic [7:0] d, input bit sof, input bit last);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_data = d; s_sof = sof; s_last = last; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_last = 1'b0;
  endtask

  task automatic s_wait_done(input logic [15:0] exp, input string req);
    logic [15:0] hold;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk(!s_done, "R7 early done", 16'(s_done), 16'h0);
    end
    @(negedge clk);
    chk(s_done, "R7 done pulse", 16'(s_done), 16'h1);
    chk(s_crc == exp, req, s_crc, exp);
    hold = s_crc;
    @(negedge clk);
    chk(!s_done, "R7 pulse width", 16'(s_done), 16'h0);
    chk(s_crc == hold, "R8 hold after done", s_crc, hold);
  endtask

  task automatic f_frame(input int n, input logic [15:0] exp, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(f_ready, "R6 ready", 16'(f_ready), 16'h1);
      if (i > 0) chk(!f_done, "R7 fused early done", 16'(f_done), 16'h0);
      f_data = frame[i]; f_sof = (i == 0); f_last = (i == n - 1); f_valid = 1'b1;
    end
    @(negedge clk);
    f_valid = 1'b0; f_sof = 1'b0; f_last = 1'b0;
    chk(f_done, "R7 fused done", 16'(f_done), 16'h1);
    chk(f_crc == exp, req, f_crc, exp);
    @(negedge clk);
    chk(!f_done, "R7 fused pulse width", 16'(f_done), 16'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    s_sof = 0; s_valid = 0; s_last = 0; s_data = 0;
    f_sof = 0; f_valid = 0; f_last = 0; f_data = 0;
    repeat (3) @(negedge clk);
    chk(s_crc == 16'hFFFF, "R9 reset crc", s_crc, 16'hFFFF);
    chk(s_ready && !s_done, "R9 reset ready/done", {14'h0, s_ready, s_done}, 16'h2);
    chk(f_crc == 16'hFFFF && f_ready, "R9 fused reset", f_crc, 16'hFFFF);
    rst_n = 1'b1;
  endtask

  task automatic t_known_answer();
    s_send(8'h48, 1'b1, 1'b0);
    chk(s_crc == 16'hB7FF, "R3 absorb 0x48 (R2 preset)", s_crc, 16'hB7FF);
    @(negedge clk);
    chk(s_crc == 16'h7FDF, "R1 first step", s_crc, 16'h7FDF);
    s_send(8'h69, 1'b0, 1'b1);
    s_wait_done(16'h64E5, "R4 known answer");
  endtask

  task automatic t_busy_ignore();
    s_send(8'h48, 1'b1, 1'b0);
    s_data = 8'hAA; s_sof = 1'b1; s_valid = 1'b1;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk(!s_ready, "R5 ready low while stepping", 16'(s_ready), 16'h0);
      if (i == 1) chk(s_crc == 16'h7FDF, "R5 step unaffected", s_crc, 16'h7FDF);
      if (i == 4) begin s_valid = 1'b0; s_sof = 1'b0; end
    end
    @(negedge clk);
    chk(s_ready, "R5 ready after steps", 16'(s_ready), 16'h1);
    s_send(8'h69, 1'b0, 1'b1);
    s_wait_done(16'h64E5, "R5 ignored busy input");
  endtask

  task automatic t_continue_and_hold();
    logic [15:0] exp;
    exp = ref_byte(16'h64E5, 8'hAB);
    s_send(8'hAB, 1'b0, 1'b1);
    chk(s_crc == (16'h64E5 ^ 16'hAB00), "R3 continue absorb", s_crc, 16'h64E5 ^ 16'hAB00);
    for (int i = 1; i < 8; i++) @(negedge clk);
    @(negedge clk);
    chk(s_done && s_crc == exp, "R3 continue result", s_crc, exp);
    repeat (5) begin
      @(negedge clk);
      chk(s_crc == exp && !s_done, "R8 idle hold", s_crc, exp);
    end
  endtask

  task automatic t_single_byte();
    s_send(8'h00, 1'b1, 1'b1);
    s_wait_done(ref_byte(16'hFFFF, 8'h00), "R2 single byte frame");
  endtask

  task automatic t_restart();
    s_send(8'h12, 1'b1, 1'b0);
    s_send(8'h34, 1'b0, 1'b0);
    for (int i = 1; i < 9; i++) begin
      @(negedge clk);
      chk(!s_done, "R7 no done without last", 16'(s_done), 16'h0);
    end
    s_send(8'h48, 1'b1, 1'b0);
    chk(s_crc == 16'hB7FF, "R10 restart preset", s_crc, 16'hB7FF);
    s_send(8'h69, 1'b0, 1'b1);
    s_wait_done(16'h64E5, "R10 restart result");
  endtask

  task automatic t_long_serial();
    logic [15:0] exp = 16'hFFFF;
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) ^ (i << 5));
      exp = ref_byte(exp, d);
      s_send(d, i == 0, i == 9);
    end
    s_wait_done(exp, "R4 ten byte frame");
  endtask

  task automatic t_reset_mid();
    s_send(8'h5A, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(s_crc == 16'hFFFF && s_ready && !s_done, "R9 reset mid byte", s_crc, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!s_done, "R9 abandoned byte no done", 16'(s_done), 16'h0);
    end
    s_send(8'h48, 1'b0, 1'b0);
    chk(s_crc == 16'hB7FF, "R9 continues from preset", s_crc, 16'hB7FF);
  endtask

  task automatic t_fused();
    logic [15:0] exp = 16'hFFFF;
    frame[0] = 8'h48; frame[1] = 8'h69;
    f_frame(2, 16'h64E5, "R6 fused known answer");
    for (int i = 0; i < 12; i++) begin
      frame[i] = 8'((i * 53 + 7) ^ 8'hC3);
      exp = ref_byte(exp, frame[i]);
    end
    f_frame(12, exp, "R6 fused twelve bytes");
    frame[0] = 8'h48;
    f_frame(1, ref_byte(16'hFFFF, 8'h48), "R2 fused reload");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    t_reset();
    t_known_answer();
    t_busy_ignore();
    t_continue_and_hold();
    t_single_byte();
    t_restart();
    t_long_serial();
    t_fused();
    t_reset_mid();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule